// File: doc/BRIEF.md
# Sensor Fault Output Override

This block watches nine fault comparators from the front end of a bridge-sensor signal chain and decides how the analog output stage is driven. Four comparators watch the sensor inputs. They form the external group. The other five watch the front-end amplifier nodes: two amplifiers are each checked for saturation to the positive supply and to ground, and a third is checked for a common-mode violation. These five form the internal group. A comparator that is high reports a fault.

Each comparator output is asynchronous and passes through a two-flop synchronizer. The synchronized bits of each group are ORed into one group flag. Each group has its own enable and its own forced level. When an enabled group flags a fault, the output stage receives a command to drive the high rail or ground in place of the linear signal. If both groups force the output, the external group decides the level. A readable alarm status word tracks the synchronized comparators and the two flags while the output is enabled. While the output is disabled, the word holds the value it had just before the disable.

Top module: `sensor_fault_guard`

## Requirements
- R1: After reset, alarmStatus is 0, both group flags are 0 and driveCmd is 00.
- R2: alarmStatus bits 3..0 hold compExt in the order positive-input-low (bit 0), positive-input-high (bit 1), negative-input-low (bit 2), negative-input-high (bit 3). Bits 13..9 hold compInt[4:0]. Bit 7 holds the external flag and bit 8 the internal flag. Bits 6..4, 15 and 14 read 0.
- R3: extFlag is the OR of the four synchronized external comparators. intFlag is the OR of the five synchronized internal comparators.
- R4: When cfgCtl[3] (external enable) is 1 and extFlag is 1, driveCmd is 10 if cfgCtl[1] is 1 and 01 if cfgCtl[1] is 0.
- R5: When cfgCtl[2] (internal enable) is 1, intFlag is 1, and the external group is not forcing, driveCmd is 10 if cfgCtl[0] is 1 and 01 if cfgCtl[0] is 0.
- R6: When both groups are enabled and both flag a fault, the external polarity cfgCtl[1] alone selects the level, even when it is opposite to cfgCtl[0].
- R7: When no enabled group flags a fault, driveCmd is 00 (linear). A fault in a disabled group does not change driveCmd. The code 11 never appears.
- R8: While outEn is 1, alarmStatus is reloaded each cycle from the live synchronized state. While outEn is 0, it keeps the value it held before the disable, and the flags and driveCmd stay live.
- R9: A comparator change made before clock edge k shows on the flags and driveCmd after edge k+1, and on alarmStatus after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| compExt | input | 4 | External comparator outputs, asynchronous, 1 = fault |
| compInt | input | 5 | Internal comparator outputs, asynchronous, 1 = fault |
| cfgCtl | input | 4 | {external enable, internal enable, external polarity, internal polarity} |
| outEn | input | 1 | Output enabled; while 0 the status word is frozen |
| alarmStatus | output | 16 | Alarm status word |
| extFlag | output | 1 | External group fault flag |
| intFlag | output | 1 | Internal group fault flag |
| driveCmd | output | 2 | 00 linear, 01 force low, 10 force high |

## Verification
The hardest state to reach from the ports is a frozen status word that disagrees with the live flags and drive command. The comparator inputs must change in the same cycle that outEn drops, so that the new faults reach the flags while the status word still shows the earlier pattern. The bench drives both changes on one falling edge and then checks the frozen word and the live outputs side by side. It also checks the two- and three-edge latencies one edge at a time.

// File: rtl/fguard_pkg.sv
package fguard_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;
  } fg_strobe_t;

  typedef enum logic [1:0] {
    DRV_LINEAR = 2'b00,
    DRV_LOW    = 2'b01,
    DRV_HIGH   = 2'b10
  } drive_e;

  // cfgCtl field positions
  localparam int CFG_EXT_EN  = 3;
  localparam int CFG_INT_EN  = 2;
  localparam int CFG_EXT_POL = 1;
  localparam int CFG_INT_POL = 0;
endpackage

// File: rtl/fguard_datapath.sv
module fguard_datapath
  import fguard_pkg::*;
#(
  parameter int EXT_N       = 4,
  parameter int INT_N       = 5,
  parameter int STAT_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_FLAG_BIT = 7,
  parameter int INT_FLAG_BIT = 8,
  parameter int INT_LSB      = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [EXT_N-1:0] compExt,
  input  logic [INT_N-1:0] compInt,
  input  fg_strobe_t       strobe,
  output logic             extFlag,
  output logic             intFlag,
  output logic [STAT_W-1:0] status
);
  localparam int NBITS = EXT_N + INT_N;

  logic [NBITS-1:0] rawBits;
  logic [NBITS-1:0] syncChain [SYNC_STAGES];
  logic [EXT_N-1:0] syncExt;
  logic [INT_N-1:0] syncInt;
  logic [STAT_W-1:0] liveStatus;

  assign rawBits = {compInt, compExt};

  // Per-stage synchronizer registers
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncChain[s] <= '0;
      end else begin
        if (s == 0) syncChain[s] <= rawBits;
        else        syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncExt = syncChain[SYNC_STAGES-1][EXT_N-1:0];
  assign syncInt = syncChain[SYNC_STAGES-1][NBITS-1:EXT_N];

  assign extFlag = |syncExt;
  assign intFlag = |syncInt;

  always_comb begin
    liveStatus = '0;
    liveStatus[EXT_N-1:0]        = syncExt;
    liveStatus[INT_LSB +: INT_N] = syncInt;
    liveStatus[EXT_FLAG_BIT]     = extFlag;
    liveStatus[INT_FLAG_BIT]     = intFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               status <= '0;
    else if (strobe.capture) status <= liveStatus;
  end

  // R8: status holds while no capture strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(status));

  // R8: a capture loads the synchronized external bits
  p_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> status[EXT_N-1:0] == $past(syncExt));

  // R2: unused status bits stay zero
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    status[EXT_FLAG_BIT-1:EXT_N] == '0);
endmodule

// File: rtl/fguard_ctrl.sv
module fguard_ctrl
  import fguard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       outEn,
  input  logic [3:0] cfgCtl,
  input  logic       extFlag,
  input  logic       intFlag,
  output fg_strobe_t strobe,
  output logic [1:0] driveCmd
);
  logic extForce;
  logic intForce;
  drive_e driveSel;

  assign extForce = cfgCtl[CFG_EXT_EN] & extFlag;
  assign intForce = cfgCtl[CFG_INT_EN] & intFlag;

  always_comb begin
    strobe = '0;
    strobe.capture = outEn;
  end

  // External group is checked first so it wins any conflict
  always_comb begin
    if (extForce)      driveSel = cfgCtl[CFG_EXT_POL] ? DRV_HIGH : DRV_LOW;
    else if (intForce) driveSel = cfgCtl[CFG_INT_POL] ? DRV_HIGH : DRV_LOW;
    else               driveSel = DRV_LINEAR;
  end

  assign driveCmd = driveSel;

  p_ext_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCtl[3] && extFlag) |-> driveCmd == {cfgCtl[1], !cfgCtl[1]});

  p_int_force_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCtl[2] && intFlag && !(cfgCtl[3] && extFlag))
      |-> driveCmd == {cfgCtl[0], !cfgCtl[0]});

  p_linear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!(cfgCtl[3] && extFlag) && !(cfgCtl[2] && intFlag)) |-> driveCmd == 2'b00);

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    driveCmd != 2'b11);
endmodule

// File: rtl/sensor_fault_guard.sv
module sensor_fault_guard
  import fguard_pkg::*;
#(
  parameter int EXT_N       = 4,
  parameter int INT_N       = 5,
  parameter int STAT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EXT_N-1:0]  compExt,
  input  logic [INT_N-1:0]  compInt,
  input  logic [3:0]        cfgCtl,
  input  logic              outEn,
  output logic [STAT_W-1:0] alarmStatus,
  output logic              extFlag,
  output logic              intFlag,
  output logic [1:0]        driveCmd
);
  fg_strobe_t strobe;

  fguard_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .outEn    (outEn),
    .cfgCtl   (cfgCtl),
    .extFlag  (extFlag),
    .intFlag  (intFlag),
    .strobe   (strobe),
    .driveCmd (driveCmd)
  );

  fguard_datapath #(
    .EXT_N       (EXT_N),
    .INT_N       (INT_N),
    .STAT_W      (STAT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .compExt (compExt),
    .compInt (compInt),
    .strobe  (strobe),
    .extFlag (extFlag),
    .intFlag (intFlag),
    .status  (alarmStatus)
  );
endmodule

// File: tb/test_sensor_fault_guard.sv
`timescale 1ns/1ps
module test_sensor_fault_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  compExt = '0;
  logic [4:0]  compInt = '0;
  logic [3:0]  cfgCtl = '0;
  logic        outEn = 1'b1;
  logic [15:0] alarmStatus;
  logic        extFlag;
  logic        intFlag;
  logic [1:0]  driveCmd;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sensor_fault_guard i_sensor_fault_guard (
    .clk(clk), .rstN(rstN), .compExt(compExt), .compInt(compInt),
    .cfgCtl(cfgCtl), .outEn(outEn), .alarmStatus(alarmStatus),
    .extFlag(extFlag), .intFlag(intFlag), .driveCmd(driveCmd)
  );

  // cfg = {extEn, intEn, extPol, intPol}
  typedef struct packed {
    logic [3:0] cfg;
    logic [3:0] ext;
    logic [4:0] intc;
    logic [1:0] drv;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0000, 4'b0000, 5'b00000, 2'b00},
    '{4'b1010, 4'b0001, 5'b00000, 2'b10},
    '{4'b1000, 4'b0010, 5'b00000, 2'b01},
    '{4'b0101, 4'b0000, 5'b00001, 2'b10},
    '{4'b0100, 4'b0000, 5'b10000, 2'b01},
    '{4'b1101, 4'b1000, 5'b00100, 2'b01},
    '{4'b1110, 4'b0100, 5'b00010, 2'b10},
    '{4'b0011, 4'b1111, 5'b11111, 2'b00},
    '{4'b1011, 4'b0000, 5'b01000, 2'b00},
    '{4'b0111, 4'b0001, 5'b00000, 2'b00},
    '{4'b1101, 4'b0000, 5'b00001, 2'b10}
  };

  function automatic logic [15:0] expStatus(logic [3:0] e, logic [4:0] i);
    return {2'b00, i, |i, |e, 3'b000, e};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    check("R1 status", alarmStatus, 16'h0);
    check("R1 flags", {14'b0, extFlag, intFlag}, 16'h0);
    check("R1 drive", {14'b0, driveCmd}, 16'h0);
    step(2);
    rstN = 1'b1;
    step(1);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      cfgCtl  = VECS[v].cfg;
      compExt = VECS[v].ext;
      compInt = VECS[v].intc;
      step(3);
      check("R4/R5/R6/R7 drive", {14'b0, driveCmd}, {14'b0, VECS[v].drv});
      check("R3 flags", {14'b0, extFlag, intFlag},
            {14'b0, |VECS[v].ext, |VECS[v].intc});
      check("R2 status", alarmStatus, expStatus(VECS[v].ext, VECS[v].intc));
    end

    // R9: latency, one edge at a time
    compExt = '0; compInt = '0; cfgCtl = 4'b1010;
    step(3);
    compExt = 4'b0100;
    step(1);
    check("R9 flag after one edge", {15'b0, extFlag}, 16'h0);
    check("R9 drive after one edge", {14'b0, driveCmd}, 16'h0);
    step(1);
    check("R9 flag after two edges", {15'b0, extFlag}, 16'h1);
    check("R9 drive after two edges", {14'b0, driveCmd}, 16'h2);
    check("R9 status after two edges", alarmStatus, 16'h0);
    step(1);
    check("R9 status after three edges", alarmStatus, expStatus(4'b0100, 5'b0));

    // R8: freeze while outEn low, with comparators changing on the same edge
    compExt = 4'b0001; compInt = 5'b00000; cfgCtl = 4'b0100;
    step(3);
    check("R8 tracking", alarmStatus, expStatus(4'b0001, 5'b0));
    outEn = 1'b0;
    compExt = 4'b0000; compInt = 5'b10010;
    step(4);
    check("R8 frozen status", alarmStatus, expStatus(4'b0001, 5'b0));
    check("R8 live flags", {14'b0, extFlag, intFlag}, 16'h1);
    check("R8 live drive", {14'b0, driveCmd}, 16'h1);
    outEn = 1'b1;
    step(1);
    check("R8 resume", alarmStatus, expStatus(4'b0000, 5'b10010));

    // R1: reset clears while faults are present
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears status", alarmStatus, 16'h0);
    check("R1 reset clears drive", {14'b0, driveCmd}, 16'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule